// File: doc/BRIEF.md
# Counter-Mode Keystream Datapath

This block turns an external 128-bit forward block cipher into a counter-mode stream cipher. It keeps a 128-bit counter block, with a 96-bit nonce in its upper bits and a 32-bit big-endian counter in its lower bits. For every data block it accepts, it sends the counter block to the cipher engine and XORs the returned keystream with the data. It then advances the counter. Encryption and decryption are the same operation, so the engine only ever runs in its forward direction.

A short final block is zero padded before the XOR, and its unused bytes are forced to zero in the result. An optional lane-reordering stage, selected by a 2-bit data-type input, is applied to the data on entry and again on exit. A load strobe writes the nonce and the counter. A 3-bit chaining-mode input enables the block only for the counter-mode code. The data input, data output and engine request each use a valid/ready pair. The engine answers with a one-cycle response strobe.

Top module: `ctr_keystream_xor`

## Requirements
- R1: After reset, out_valid and eng_req_valid are low, the nonce is zero and the counter is 1. The first block's engine request is therefore {96'h0, 32'h1}.
- R2: in_ready is high only when chain_mode equals 3'b010. With any other code, no input is accepted and no engine request is raised.
- R3: While eng_req_valid is high, eng_req_block carries the nonce in bits [127:32] and the counter in bits [31:0].
- R4: For a full block (in_nbytes = 0), out_data equals swap(swap(in_data) XOR keystream), where keystream is the engine's response to that block's request.
- R5: The counter increases by one after each completed block and wraps from 32'hFFFFFFFF to 0. The wrap never changes the nonce.
- R6: When in_nbytes = k with k from 1 to 15, only bytes 0..k-1 are kept, and byte i occupies bits [127-8i -: 8]. The other bytes are zero in the input before the XOR and zero in the result before the output swap.
- R7: Within each 32-bit word, data_type selects the reordering. 0 leaves the word unchanged, 1 exchanges the two 16-bit halves, 2 reverses the four bytes, and 3 reverses the bits inside each byte. The code is captured with the input block and applied again to the output.
- R8: Exactly one block is in flight. in_ready stays low from the accepting edge until the output block has been taken.
- R9: A load strobe has no effect on the nonce or the counter while a block is in flight.
- R10: A load strobe while idle writes ld_nonce and ld_count. The next block's request uses these values.
- R11: A pending output holds out_data stable until out_ready. A pending engine request holds eng_req_block stable until eng_req_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chain_mode | input | 3 | Chaining-mode select; 3'b010 enables the block |
| data_type | input | 2 | Lane reordering code |
| ld_en | input | 1 | Load strobe for the nonce and counter |
| ld_nonce | input | 96 | Nonce value to load |
| ld_count | input | 32 | Counter value to load |
| in_valid | input | 1 | Input block valid |
| in_ready | output | 1 | Input block accepted |
| in_data | input | 128 | Input block, byte 0 in bits [127:120] |
| in_nbytes | input | 4 | Valid byte count; 0 means all 16 |
| eng_req_valid | output | 1 | Counter block offered to the engine |
| eng_req_ready | input | 1 | Engine takes the counter block |
| eng_req_block | output | 128 | Counter block {nonce, counter} |
| eng_rsp_valid | input | 1 | Keystream strobe from the engine |
| eng_rsp_ks | input | 128 | Keystream block |
| out_valid | output | 1 | Result block valid |
| out_ready | input | 1 | Result block taken |
| out_data | output | 128 | Result block |

## Verification
The bench covers every data-type code against every valid-byte count. A swap applied on only one side would show up as reordered output, and padding applied in the wrong lane domain would leave keystream bytes where zeros belong. Loading the counter near 2^32 tests the wrap. A design that carries into the nonce, or that skips or repeats a counter value, would send the engine a wrong request. A load pulsed just after a block is accepted, an output held back for several cycles, and a stalled engine handshake test R9 and R11. The first two would catch a counter corrupted mid-flight or a result that changes before it is taken. The mode sweep checks that no code except the counter-mode code opens the input.

// File: rtl/ctrx_pkg.sv
package ctrx_pkg;
  localparam int BLK_W    = 128;
  localparam int NONCE_W  = 96;
  localparam int CNT_W    = BLK_W - NONCE_W;
  localparam int N_BYTES  = BLK_W / 8;
  localparam int N_WORDS  = BLK_W / 32;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_OUT} ctrx_state_e;
  typedef enum logic [1:0] {DT_NONE, DT_HALF, DT_BYTE, DT_BIT} ctrx_dtype_e;

  function automatic logic [7:0] bitrev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  // byte i lives in bits [BLK_W-1-8i -: 8]; count 0 keeps every byte
  function automatic logic [BLK_W-1:0] keep_mask(input logic [3:0] nbytes);
    logic [BLK_W-1:0] m;
    for (int i = 0; i < N_BYTES; i++)
      m[BLK_W-1-8*i -: 8] = ((nbytes == 4'd0) || (i < int'(nbytes))) ? 8'hFF : 8'h00;
    return m;
  endfunction

  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] c);
    return c + 1'b1;
  endfunction
endpackage

// File: rtl/ctrx_lane_swap.sv
module ctrx_lane_swap
  import ctrx_pkg::*;
#(
  parameter int WORDS = N_WORDS
) (
  input  logic [1:0]          dtype,
  input  logic [32*WORDS-1:0] din,
  output logic [32*WORDS-1:0] dout
);
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [31:0] x;
    assign x = din[32*w +: 32];
    always_comb begin
      unique case (ctrx_dtype_e'(dtype))
        DT_NONE: dout[32*w +: 32] = x;
        DT_HALF: dout[32*w +: 32] = {x[15:0], x[31:16]};
        DT_BYTE: dout[32*w +: 32] = {x[7:0], x[15:8], x[23:16], x[31:24]};
        default: dout[32*w +: 32] = {bitrev8(x[31:24]), bitrev8(x[23:16]),
                                     bitrev8(x[15:8]), bitrev8(x[7:0])};
      endcase
    end
  end
endmodule

// File: rtl/ctrx_ctr_reg.sv
module ctrx_ctr_reg
  import ctrx_pkg::*;
#(
  parameter logic [CNT_W-1:0] CNT_INIT = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_en,
  input  logic               busy,
  input  logic               adv,
  input  logic [NONCE_W-1:0] ld_nonce,
  input  logic [CNT_W-1:0]   ld_count,
  output logic [NONCE_W-1:0] nonce,
  output logic [CNT_W-1:0]   cnt
);
  logic load_ok;
  assign load_ok = ld_en && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nonce <= '0;
      cnt   <= CNT_INIT;
    end else if (adv) begin
      cnt <= cnt_step(cnt);
    end else if (load_ok) begin
      nonce <= ld_nonce;
      cnt   <= ld_count;
    end
  end

  assert_cnt_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (cnt == $past(cnt) + 32'd1) && $stable(nonce));
  assert_load_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && busy && !adv) |=> $stable(nonce) && $stable(cnt));
endmodule

// File: rtl/ctrx_ctl.sv
module ctrx_ctl
  import ctrx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mode_ok,
  input  logic in_valid,
  input  logic eng_req_ready,
  input  logic eng_rsp_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic in_take,
  output logic eng_req_valid,
  output logic rsp_take,
  output logic out_valid,
  output logic busy
);
  ctrx_state_e st, st_nx;

  assign in_ready      = (st == ST_IDLE) && mode_ok;
  assign in_take       = in_valid && in_ready;
  assign eng_req_valid = (st == ST_REQ);
  assign rsp_take      = (st == ST_WAIT) && eng_rsp_valid;
  assign out_valid     = (st == ST_OUT);
  assign busy          = (st != ST_IDLE);

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE: if (in_take)       st_nx = ST_REQ;
      ST_REQ:  if (eng_req_ready) st_nx = ST_WAIT;
      ST_WAIT: if (eng_rsp_valid) st_nx = ST_OUT;
      default: if (out_ready)     st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  assert_single_flight_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_take |=> !in_ready);
  assert_out_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req_valid && !eng_req_ready) |=> eng_req_valid);
endmodule

// File: rtl/ctr_keystream_xor.sv
module ctr_keystream_xor
  import ctrx_pkg::*;
#(
  parameter logic [2:0]       CTR_SEL  = 3'b010,
  parameter logic [CNT_W-1:0] CNT_INIT = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         chain_mode,
  input  logic [1:0]         data_type,
  input  logic               ld_en,
  input  logic [NONCE_W-1:0] ld_nonce,
  input  logic [CNT_W-1:0]   ld_count,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [BLK_W-1:0]   in_data,
  input  logic [3:0]         in_nbytes,
  output logic               eng_req_valid,
  input  logic               eng_req_ready,
  output logic [BLK_W-1:0]   eng_req_block,
  input  logic               eng_rsp_valid,
  input  logic [BLK_W-1:0]   eng_rsp_ks,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [BLK_W-1:0]   out_data
);
  logic               mode_ok, in_take, rsp_take, busy;
  logic [NONCE_W-1:0] nonce;
  logic [CNT_W-1:0]   cnt;
  logic [BLK_W-1:0]   sw_in, keep, din_q, mask_q, res_q;
  logic [1:0]         dt_q;

  assign mode_ok = (chain_mode == CTR_SEL);
  assign keep    = keep_mask(in_nbytes);

  ctrx_ctl u_ctl (
    .clk, .rst_n, .mode_ok, .in_valid, .eng_req_ready, .eng_rsp_valid,
    .out_ready, .in_ready, .in_take, .eng_req_valid, .rsp_take,
    .out_valid, .busy
  );

  ctrx_ctr_reg #(.CNT_INIT(CNT_INIT)) u_ctr (
    .clk, .rst_n, .ld_en, .busy, .adv(rsp_take),
    .ld_nonce, .ld_count, .nonce, .cnt
  );

  assign eng_req_block = {nonce, cnt};

  ctrx_lane_swap u_swap_in  (.dtype(data_type), .din(in_data), .dout(sw_in));
  ctrx_lane_swap u_swap_out (.dtype(dt_q),      .din(res_q),   .dout(out_data));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      din_q  <= '0;
      mask_q <= '0;
      dt_q   <= '0;
      res_q  <= '0;
    end else begin
      if (in_take) begin
        din_q  <= sw_in & keep;
        mask_q <= keep;
        dt_q   <= data_type;
      end
      if (rsp_take) res_q <= (din_q ^ eng_rsp_ks) & mask_q;
    end
  end

  assert_mode_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_ok |-> !in_ready);
  assert_req_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req_valid && !eng_req_ready) |=> $stable(eng_req_block));
  assert_out_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_data));
  assert_pad_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((res_q & ~mask_q) == '0));
endmodule

// File: tb/ctr_keystream_xor_test.sv
`timescale 1ns/1ps
module ctr_keystream_xor_test;
  logic         clk = 0;
  logic         rst_n = 0;
  logic [2:0]   chain_mode = 3'b010;
  logic [1:0]   data_type = 0;
  logic         ld_en = 0;
  logic [95:0]  ld_nonce = 0;
  logic [31:0]  ld_count = 0;
  logic         in_valid = 0;
  logic         in_ready;
  logic [127:0] in_data = 0;
  logic [3:0]   in_nbytes = 0;
  logic         eng_req_valid;
  logic         eng_req_ready = 0;
  logic [127:0] eng_req_block;
  logic         eng_rsp_valid = 0;
  logic [127:0] eng_rsp_ks = 0;
  logic         out_valid;
  logic         out_ready = 0;
  logic [127:0] out_data;

  int n_cmp = 0, n_bad = 0;
  int eng_gap = 0, eng_lat = 0;
  logic [127:0] seen_blk = 0;
  logic [95:0]  m_nonce = 0;
  logic [31:0]  m_cnt = 1;
  logic         done = 0;

  always #2 clk = ~clk;

  ctr_keystream_xor uut (.*);

  function automatic logic [127:0] stub_ks(input logic [127:0] b);
    return {b[100:0], b[127:101]} ^ 128'hC3A5_0F1E_7D29_B486_5A3C_E1F0_9D27_46B8
           ^ {4{b[31:0] * 32'h9E37_79B9}};
  endfunction

  // source bit within a word = bit XOR k, k chosen by the data-type code
  function automatic logic [127:0] tb_swap(input logic [127:0] d, input logic [1:0] dt);
    logic [127:0] r;
    int k;
    k = (dt == 2'd0) ? 0 : (dt == 2'd1) ? 16 : (dt == 2'd2) ? 24 : 7;
    for (int i = 0; i < 128; i++) r[i] = d[(i / 32) * 32 + ((i % 32) ^ k)];
    return r;
  endfunction

  function automatic logic [127:0] tb_pad(input int nb);
    logic [127:0] m = '0;
    int lim = (nb == 0) ? 16 : nb;
    for (int i = 0; i < lim; i++) m[127 - 8*i -: 8] = 8'hFF;
    return m;
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // stub cipher engine
  initial begin
    forever begin
      @(negedge clk);
      if (eng_req_valid) begin
        logic [127:0] first;
        first = eng_req_block;
        repeat (eng_gap) @(negedge clk);
        check(eng_req_block == first, "R11 req hold", eng_req_block, first);
        seen_blk = eng_req_block;
        eng_req_ready = 1;
        @(negedge clk);
        eng_req_ready = 0;
        repeat (eng_lat) @(negedge clk);
        eng_rsp_ks = stub_ks(seen_blk);
        eng_rsp_valid = 1;
        @(negedge clk);
        eng_rsp_valid = 0;
      end
    end
  end

  task automatic run_block(input logic [127:0] d, input int nb, input int dt,
                           input int hold, input bit busy_load, input string tag);
    logic [127:0] exp, got, pm, ks;
    data_type = dt[1:0]; in_nbytes = nb[3:0]; in_data = d;
    @(negedge clk);
    in_valid = 1;
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1 in_valid = 0;
    data_type = ~dt[1:0];
    if (busy_load) begin
      ld_en = 1; ld_nonce = 96'hBAD0_BAD0_BAD0_BAD0_BAD0_BAD0; ld_count = 32'h1234_5678;
      @(posedge clk); #1 ld_en = 0;
    end
    @(negedge clk);
    check(!in_ready, "R8 in_ready after accept", {127'd0, in_ready}, 128'd0);
    while (!out_valid) @(negedge clk);
    pm  = tb_pad(nb);
    ks  = stub_ks({m_nonce, m_cnt});
    exp = tb_swap(((tb_swap(d, dt[1:0]) & pm) ^ ks) & pm, dt[1:0]);
    got = out_data;
    check(got == exp, tag, got, exp);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check(out_valid && out_data == got && !in_ready, "R11 R8 out hold", out_data, got);
    end
    out_ready = 1;
    @(posedge clk); #1 out_ready = 0;
    check(seen_blk == {m_nonce, m_cnt}, "R3 R5 R9 request block", seen_blk, {m_nonce, m_cnt});
    m_cnt = m_cnt + 1;
  endtask

  task automatic load(input logic [95:0] n, input logic [31:0] c);
    @(negedge clk);
    ld_en = 1; ld_nonce = n; ld_count = c;
    @(negedge clk);
    ld_en = 0;
    m_nonce = n; m_cnt = c;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!out_valid && !eng_req_valid, "R1 reset outputs",
          {126'd0, out_valid, eng_req_valid}, 128'd0);
    rst_n = 1;
    @(negedge clk);
    check(in_ready, "R1 idle ready", {127'd0, in_ready}, 128'd1);
    // R1: first block uses nonce 0, counter 1
    run_block(128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF, 0, 0, 0, 0, "R1 R4 first block");

    // R2: mode sweep
    for (int m = 0; m < 8; m++) begin
      chain_mode = m[2:0];
      in_valid = (m != 2);
      @(negedge clk);
      @(negedge clk);
      check(in_ready == (m == 2) && !eng_req_valid, "R2 mode gate",
            {126'd0, in_ready, eng_req_valid}, {126'd0, (m == 2), 1'b0});
    end
    in_valid = 0;
    chain_mode = 3'b010;

    // R10: load while idle
    load(96'hA1B2_C3D4_E5F6_0718_293A_4B5C, 32'h0000_0100);
    // R4 R6 R7: sweep data types and byte counts
    for (int dt = 0; dt < 4; dt++) begin
      for (int nb = 0; nb < 16; nb++) begin
        logic [127:0] d;
        d = {4{32'h1F2E_3D4C * (dt * 16 + nb + 3)}} ^ {dt[7:0], 120'h5A5A_0F0F_3C3C_9696_C3C3_F0F0_A5A5_69};
        eng_gap = nb % 3; eng_lat = (nb + dt) % 4;
        run_block(d, nb, dt, (nb % 4 == 1) ? 3 : 0, 0, "R4 R6 R7 lane/pad result");
      end
    end

    // R9: load pulsed while in flight must not disturb counter or nonce
    run_block(128'hFEDC_BA98_7654_3210_0123_4567_89AB_CDEF, 0, 2, 1, 1, "R9 R4 busy load");
    run_block(128'h1357_9BDF_2468_ACE0_1357_9BDF_2468_ACE0, 5, 1, 0, 0, "R9 R6 after busy load");

    // R5: wrap from all-ones to zero, nonce unchanged
    load(96'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 32'hFFFF_FFFE);
    for (int i = 0; i < 3; i++)
      run_block({4{32'hC0DE_0000 + i}}, (i == 2) ? 7 : 0, i, 0, 0, "R5 wrap block");
    check(m_cnt == 32'd1, "R5 wrap model", {96'd0, m_cnt}, 128'd1);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule